// File: doc/BRIEF.md
# Paired-Access General Register File

This block holds the working registers of a small 8-bit processor core: thirty-two
8-bit entries. Two read ports, one for the destination operand and one for the
source operand, return entry contents combinationally. Two write paths share the
clock edge. An 8-bit port writes a single entry. A 16-bit port writes an even/odd
pair of entries at once, with the odd entry taking the high byte. The 16-bit port
carries word add/subtract-immediate results. When it is told the word is a
multiply product, it always lands the word in entries 1:0, whatever pair index it
is given.

Three fixed pairs are always visible as 16-bit pointers. The X pointer is built
from entries 27:26, Y from 29:28 and Z from 31:30, with the odd entry as the high
byte. A legality flag tells the decoder when an immediate-form instruction names a
destination index below 16. Immediate forms can only reach the upper half of the
file, so such an index is illegal.

Top module: `regfile_pairs`

## Requirements
- R1: A cycle with `rst` high at a rising edge clears all 32 entries to 0x00. Afterwards every read and every pointer output is zero.
- R2: With `wb_en` high at a rising edge, entry `wb_idx` takes `wb_data`. A read of that entry shows the new value after the edge.
- R3: `rd_data` shows entry `rd_idx` and `rs_data` shows entry `rs_idx`. Both are combinational and independent of each other.
- R4: A read of an entry that is being written in the same cycle returns the old contents until the edge. There is no write-through.
- R5: With `wp_en` high and `wp_mul` low, pair `p = wp_pair` is written at one edge. `wp_data[15:8]` goes to entry 2p+1 and `wp_data[7:0]` goes to entry 2p.
- R6: With `wp_en` and `wp_mul` both high, `wp_data` goes to entries 1 (high byte) and 0 (low byte) whatever `wp_pair` holds. No other pair changes.
- R7: If both write ports target the same entry at one edge, the pair port's byte is stored. A byte write to an entry outside the written pair still takes effect.
- R8: `ptr_x` = {entry 27, entry 26}, `ptr_y` = {entry 29, entry 28} and `ptr_z` = {entry 31, entry 30}. Each follows a write to either byte of its pair after the edge.
- R9: `imm_bad` is high exactly when `imm_mode` is high and `rd_idx` is below 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| rd_idx | input | 5 | Destination operand read index |
| rs_idx | input | 5 | Source operand read index |
| rd_data | output | 8 | Destination operand contents |
| rs_data | output | 8 | Source operand contents |
| imm_mode | input | 1 | Current instruction is an immediate form |
| imm_bad | output | 1 | Immediate form names a lower-half destination |
| wb_en | input | 1 | Byte write enable |
| wb_idx | input | 5 | Byte write index |
| wb_data | input | 8 | Byte write data |
| wp_en | input | 1 | Pair write enable |
| wp_mul | input | 1 | Pair write is a product; force pair 0 |
| wp_pair | input | 4 | Pair index (entries 2p+1:2p) |
| wp_data | input | 16 | Pair write data, high byte to odd entry |
| ptr_x | output | 16 | Entries 27:26 |
| ptr_y | output | 16 | Entries 29:28 |
| ptr_z | output | 16 | Entries 31:30 |

## Verification
A stale or misplaced entry shows up on a read port in the same cycle that its index is selected. It is seen right after the edge that should have updated it. A fault in the pair logic appears on the pointer outputs one edge after the pair write, with no index needed. Swapped bytes, a wrong pair, a product written away from entries 1:0, or the byte port beating the pair port all surface as one wrong byte at the next read. A hidden bypass shows before the edge as a read that already carries the new value.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_DATA_W = 8;
  parameter int unsigned RF_NUM_REGS = 32;
  localparam int unsigned RF_IDX_W = $clog2(RF_NUM_REGS);
  localparam int unsigned RF_PAIR_W = RF_IDX_W - 1;

  // Pair index of the fixed pointer pairs and the first entry immediates reach.
  parameter int unsigned RF_X_PAIR = 13;
  parameter int unsigned RF_Y_PAIR = 14;
  parameter int unsigned RF_Z_PAIR = 15;
  parameter int unsigned RF_IMM_BASE = 16;
  parameter int unsigned RF_MUL_PAIR = 0;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned MUL_PAIR = 0,
  localparam int unsigned IDX_W = $clog2(NUM_REGS),
  localparam int unsigned PAIR_W = IDX_W - 1,
  localparam int unsigned NUM_PAIRS = NUM_REGS / 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wb_en,
  input  logic [IDX_W-1:0]                 wb_idx,
  input  logic [DATA_W-1:0]                wb_data,
  input  logic                             wp_en,
  input  logic                             wp_mul,
  input  logic [PAIR_W-1:0]                wp_pair,
  input  logic [2*DATA_W-1:0]              wp_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  logic [PAIR_W-1:0] pair_sel;

  always_comb begin
    pair_sel = wp_mul ? PAIR_W'(MUL_PAIR) : wp_pair;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic pair_hit;
    assign pair_hit = wp_en && (pair_sel == PAIR_W'(p));

    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int unsigned ENT = 2 * p + h;
      logic byte_hit;
      assign byte_hit = wb_en && (wb_idx == IDX_W'(ENT));

      always_ff @(posedge clk) begin
        if (rst) begin
          regs_q[ENT] <= '0;
        end else if (pair_hit) begin
          regs_q[ENT] <= wp_data[h*DATA_W +: DATA_W];
        end else if (byte_hit) begin
          regs_q[ENT] <= wb_data;
        end
      end
    end
  end
endmodule

// File: rtl/rf_ptr_tap.sv
module rf_ptr_tap #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned PAIR = 13
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
  output logic [2*DATA_W-1:0]             ptr
);
  localparam int unsigned LO = 2 * PAIR;
  localparam int unsigned HI = LO + 1;

  always_comb begin
    ptr = {regs_q[HI], regs_q[LO]};
  end
endmodule

// File: rtl/rf_imm_check.sv
module rf_imm_check #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IMM_BASE = 16,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             imm_mode,
  input  logic [IDX_W-1:0] idx,
  output logic             bad
);
  always_comb begin
    bad = imm_mode && (idx < IDX_W'(IMM_BASE));
  end
endmodule

// File: rtl/regfile_pairs.sv
module regfile_pairs
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned NUM_REGS = RF_NUM_REGS,
  localparam int unsigned IDX_W = $clog2(NUM_REGS),
  localparam int unsigned PAIR_W = IDX_W - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [IDX_W-1:0]    rs_idx,
  output logic [DATA_W-1:0]   rd_data,
  output logic [DATA_W-1:0]   rs_data,
  input  logic                imm_mode,
  output logic                imm_bad,
  input  logic                wb_en,
  input  logic [IDX_W-1:0]    wb_idx,
  input  logic [DATA_W-1:0]   wb_data,
  input  logic                wp_en,
  input  logic                wp_mul,
  input  logic [PAIR_W-1:0]   wp_pair,
  input  logic [2*DATA_W-1:0] wp_data,
  output logic [2*DATA_W-1:0] ptr_x,
  output logic [2*DATA_W-1:0] ptr_y,
  output logic [2*DATA_W-1:0] ptr_z
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [2:0][2*DATA_W-1:0]        ptr_all;

  rf_bank #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .MUL_PAIR(RF_MUL_PAIR)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .wp_en(wp_en), .wp_mul(wp_mul), .wp_pair(wp_pair), .wp_data(wp_data),
    .regs_q(regs_q)
  );

  always_comb begin
    rd_data = regs_q[rd_idx];
    rs_data = regs_q[rs_idx];
  end

  localparam int unsigned PTR_PAIRS [3] = '{RF_X_PAIR, RF_Y_PAIR, RF_Z_PAIR};

  for (genvar k = 0; k < 3; k++) begin : g_ptr
    rf_ptr_tap #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PAIR(PTR_PAIRS[k])
    ) u_tap (
      .regs_q(regs_q), .ptr(ptr_all[k])
    );
  end

  assign ptr_x = ptr_all[0];
  assign ptr_y = ptr_all[1];
  assign ptr_z = ptr_all[2];

  rf_imm_check #(
    .NUM_REGS(NUM_REGS), .IMM_BASE(RF_IMM_BASE)
  ) u_imm (
    .imm_mode(imm_mode), .idx(rd_idx), .bad(imm_bad)
  );
endmodule

// File: rtl/regfile_pairs_chk.sv
module regfile_pairs_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_REGS),
  localparam int unsigned PAIR_W = IDX_W - 1
) (
  input logic                            clk,
  input logic                            rst,
  input logic [IDX_W-1:0]                rd_idx,
  input logic [DATA_W-1:0]               rd_data,
  input logic                            imm_mode,
  input logic                            imm_bad,
  input logic                            wb_en,
  input logic [IDX_W-1:0]                wb_idx,
  input logic [DATA_W-1:0]               wb_data,
  input logic                            wp_en,
  input logic                            wp_mul,
  input logic [PAIR_W-1:0]               wp_pair,
  input logic [2*DATA_W-1:0]             wp_data,
  input logic [2*DATA_W-1:0]             ptr_z,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  logic [PAIR_W-1:0] eff_pair;
  logic              wb_in_pair;

  always_comb begin
    eff_pair = wp_mul ? '0 : wp_pair;
    wb_in_pair = wp_en && (wb_idx[IDX_W-1:1] == eff_pair);
  end

  a_r2_byte_write: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !wb_in_pair) |=> regs_q[$past(wb_idx)] == $past(wb_data));

  a_r5_pair_write: assert property (@(posedge clk) disable iff (rst)
    (wp_en && !wp_mul) |=>
      {regs_q[{$past(wp_pair), 1'b1}], regs_q[{$past(wp_pair), 1'b0}]} == $past(wp_data));

  a_r6_mul_to_r1r0: assert property (@(posedge clk) disable iff (rst)
    (wp_en && wp_mul) |=> {regs_q[1], regs_q[0]} == $past(wp_data));

  a_r7_pair_wins: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_in_pair) |=>
      regs_q[$past(wb_idx)] == $past(wp_data[wb_idx[0]*DATA_W +: DATA_W]));

  a_r4_no_bypass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(rd_idx) && !$past(wb_en) && !$past(wp_en)) |-> $stable(rd_data));

  a_r8_ptr_z_follow: assert property (@(posedge clk) disable iff (rst)
    (wp_en && !wp_mul && wp_pair == PAIR_W'(15)) |=> ptr_z == $past(wp_data));

  a_r9_upper_legal: assert property (@(posedge clk) disable iff (rst)
    (rd_idx[IDX_W-1] || !imm_mode) |-> !imm_bad);
endmodule

bind regfile_pairs regfile_pairs_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/regfile_pairs_test.sv
`timescale 1ns/1ps
module regfile_pairs_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_idx, rs_idx, wb_idx;
  logic [7:0]  rd_data, rs_data, wb_data;
  logic        imm_mode, imm_bad, wb_en, wp_en, wp_mul;
  logic [3:0]  wp_pair;
  logic [15:0] wp_data, ptr_x, ptr_y, ptr_z;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regfile_pairs uut (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rs_idx(rs_idx),
    .rd_data(rd_data), .rs_data(rs_data), .imm_mode(imm_mode), .imm_bad(imm_bad),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .wp_en(wp_en), .wp_mul(wp_mul), .wp_pair(wp_pair), .wp_data(wp_data),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at falling edge, commit at rising edge, release just after.
  task automatic do_cycle(logic be, logic [4:0] bi, logic [7:0] bd,
                          logic pe, logic pm, logic [3:0] pp, logic [15:0] pd);
    @(negedge clk);
    wb_en = be; wb_idx = bi; wb_data = bd;
    wp_en = pe; wp_mul = pm; wp_pair = pp; wp_data = pd;
    @(posedge clk); #1;
    wb_en = 1'b0; wp_en = 1'b0; wp_mul = 1'b0;
  endtask

  // {wb_en, wb_idx, wb_data, wp_en, wp_mul, wp_pair, wp_data, chk_idx, expect}
  typedef logic [48:0] vec_t;
  localparam vec_t VEC [10] = '{
    {1'b1, 5'd5,  8'h3C, 1'b0, 1'b0, 4'd0,  16'h0000, 5'd5,  8'h3C}, // R2
    {1'b1, 5'd26, 8'h11, 1'b0, 1'b0, 4'd0,  16'h0000, 5'd26, 8'h11}, // R2
    {1'b0, 5'd0,  8'h00, 1'b1, 1'b0, 4'd13, 16'hBEEF, 5'd27, 8'hBE}, // R5 high
    {1'b0, 5'd0,  8'h00, 1'b1, 1'b1, 4'd7,  16'h1234, 5'd1,  8'h12}, // R6
    {1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 4'd0,  16'h0000, 5'd0,  8'h34}, // R6 low
    {1'b1, 5'd24, 8'hAA, 1'b1, 1'b0, 4'd12, 16'h5566, 5'd24, 8'h66}, // R7 pair wins
    {1'b1, 5'd3,  8'h77, 1'b1, 1'b0, 4'd14, 16'h0102, 5'd3,  8'h77}, // R7 other entry
    {1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 4'd0,  16'h0000, 5'd29, 8'h01}, // R5 pair 14
    {1'b0, 5'd0,  8'h00, 1'b1, 1'b1, 4'd6,  16'hABCD, 5'd12, 8'h00}, // R6 ignores idx
    {1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 4'd0,  16'h0000, 5'd13, 8'h00}  // R6 ignores idx
  };

  initial begin
    rst = 1'b1; rd_idx = '0; rs_idx = '0; imm_mode = 1'b0;
    wb_en = 1'b0; wb_idx = '0; wb_data = '0;
    wp_en = 1'b0; wp_mul = 1'b0; wp_pair = '0; wp_data = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    rd_idx = 5'd31; rs_idx = 5'd0; #1;
    check("R1 rd after reset", {8'h00, rd_data}, 16'h0000);
    check("R1 ptr_z after reset", ptr_z, 16'h0000);

    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VEC[i];
      do_cycle(v[48], v[47:43], v[42:35], v[34], v[33], v[32:29], v[28:13]);
      rd_idx = v[12:8]; #1;
      check($sformatf("R2/R5/R6/R7 vector %0d", i), {8'h00, rd_data}, {8'h00, v[7:0]});
    end

    // R3: both ports independent
    rd_idx = 5'd5; rs_idx = 5'd27; #1;
    check("R3 rd port", {8'h00, rd_data}, 16'h003C);
    check("R3 rs port", {8'h00, rs_data}, 16'h00BE);

    // R8: pointers
    check("R8 ptr_x after pair write", ptr_x, 16'hBEEF);
    check("R8 ptr_y after pair write", ptr_y, 16'h0102);
    do_cycle(1'b1, 5'd30, 8'h9A, 1'b0, 1'b0, 4'd0, 16'h0);
    check("R8 ptr_z low byte", ptr_z, 16'h009A);
    do_cycle(1'b1, 5'd31, 8'h4D, 1'b0, 1'b0, 4'd0, 16'h0);
    check("R8 ptr_z high byte", ptr_z, 16'h4D9A);
    do_cycle(1'b1, 5'd26, 8'h00, 1'b0, 1'b0, 4'd0, 16'h0);
    check("R8 ptr_x low byte", ptr_x, 16'hBE00);

    // R4: no write-through before the edge
    @(negedge clk);
    rd_idx = 5'd5; wb_en = 1'b1; wb_idx = 5'd5; wb_data = 8'hE1; #1;
    check("R4 old value before edge", {8'h00, rd_data}, 16'h003C);
    @(posedge clk); #1 wb_en = 1'b0;
    check("R4 new value after edge", {8'h00, rd_data}, 16'h00E1);

    // R9: immediate legality
    imm_mode = 1'b1; rd_idx = 5'd15; #1;
    check("R9 idx 15 illegal", {15'h0, imm_bad}, 16'h0001);
    rd_idx = 5'd16; #1;
    check("R9 idx 16 legal", {15'h0, imm_bad}, 16'h0000);
    rd_idx = 5'd0; #1;
    check("R9 idx 0 illegal", {15'h0, imm_bad}, 16'h0001);
    imm_mode = 1'b0; #1;
    check("R9 non-immediate", {15'h0, imm_bad}, 16'h0000);

    // R1: reset clears written entries
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    rd_idx = 5'd5; rs_idx = 5'd1; #1;
    check("R1 rd cleared", {8'h00, rd_data}, 16'h0000);
    check("R1 rs cleared", {8'h00, rs_data}, 16'h0000);
    check("R1 ptr_x cleared", ptr_x, 16'h0000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule